// File: doc/BRIEF.md
# Masked Receive Alarm Interrupt Controller

This block gathers eight receive-side alarm indications into one status word and raises a single active-low interrupt when any latched alarm is enabled in a host-written mask word. The interrupt pin is modelled as an open-drain pull-down: it reads 0 while asserted and 1 (released) otherwise. The alarm detectors and the error counters are outside the block. They supply level conditions, saturation pulses and counter reload strobes.

The bits fall into two kinds, and each kind is cleared differently. Six real-time event bits latch on the rising edge of their condition. A direct single read of the status word clears each of them, but only if its condition has ended by then. A burst read leaves them alone. Two counter-saturation bits ignore reads completely. They clear only when their counter is reloaded with a value other than all ones. Writing a 0 into a mask bit withdraws that alarm from the interrupt at once, whatever state its status bit is in.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: The status word (`rd_data_o`) and the mask word (`mask_o`) share one bit layout. Bit 7 is bipolar-violation counter saturation. Bit 6 is error counter saturation. Bit 5 is remote alarm, bit 4 is carrier loss, bit 3 is framing error, bit 2 is zero-substitution detect, bit 1 is all-ones alarm and bit 0 is sync loss. Real-time condition `evt_cond_i[i]` feeds status bit i for i = 0..5.
- R2: After a synchronous reset, the status word is 0, the mask word is 0 and `irq_n_o` is 1.
- R3: `irq_n_o` is 0 exactly when some bit is 1 in both the status word and the mask word. It follows the registers in the cycle after the clock edge that changes them.
- R4: A write (`mask_wr_i`=1) loads `mask_wdata_i` into the mask at the clock edge. A cleared mask bit releases that alarm's share of the interrupt in the next cycle and leaves the status bit unchanged. Setting the mask bit again re-asserts the interrupt while the status bit is still set.
- R5: A real-time status bit sets on a rising edge of its condition and stays set after the condition falls, even when the pulse lasts only one cycle.
- R6: A direct read (`rd_stb_i`=1, `rd_burst_i`=0) clears every real-time status bit whose condition is low at that clock edge.
- R7: A direct read does not clear a real-time bit whose condition is high at that edge. This includes a condition that rises in the same cycle as the read.
- R8: A burst read (`rd_stb_i`=1, `rd_burst_i`=1) clears nothing.
- R9: `sat_hit_i[1]` sets status bit 7 and `sat_hit_i[0]` sets bit 6. Reads of any kind never clear these bits.
- R10: `cnt_load_i[1]` reloads the bit-7 counter and `cnt_load_i[0]` reloads the bit-6 counter. A reload clears its saturation bit only when `cnt_load_val_i` is not all ones. A reload of all ones, or a reload of the other counter, leaves the bit set.
- R11: A real-time bit that a read has cleared stays clear until its condition rises again. A condition that stays low does not set it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_cond_i | input | 6 | Real-time alarm condition levels for status bits 5..0 |
| sat_hit_i | input | 2 | Counter saturation pulses (bit 1 to status 7, bit 0 to status 6) |
| cnt_load_i | input | 2 | Counter reload strobes (bit 1 to status 7, bit 0 to status 6) |
| cnt_load_val_i | input | CNT_W | Value written into the reloaded counter |
| rd_stb_i | input | 1 | Host read of the status word |
| rd_burst_i | input | 1 | Marks the read as part of a burst (no clearing) |
| rd_data_o | output | 8 | Status word |
| mask_wr_i | input | 1 | Mask word write strobe |
| mask_wdata_i | input | 8 | Mask word write data |
| mask_o | output | 8 | Mask word |
| irq_n_o | output | 1 | Interrupt, 0 = pulled low, 1 = released |

## Verification
Every result of this block is due one cycle after the clock edge that samples the stimulus. This covers a latched event, a read clear, a reload clear and a mask write. The outputs come only from registers, so the interrupt and the status and mask words are all valid one edge after the cause. The driver applies each stimulus at a falling edge and tags the expected words with the index of the next cycle. The monitor compares them at the falling edge of that cycle, half a period after the rising edge that produced them.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;

    localparam int NUM_RT  = 6;
    localparam int NUM_SAT = 2;
    localparam int ALM_W   = NUM_RT + NUM_SAT;

    // Field order is the bit order: the first field sits at bit 7.
    typedef struct packed {
        logic sat_bpv;
        logic sat_err;
        logic remote_alm;
        logic carrier_loss;
        logic frame_err;
        logic zsub_det;
        logic ais_det;
        logic sync_loss;
    } alarm_vec_t;

    typedef struct packed {
        logic strobe;
        logic burst;
    } host_rd_t;

    function automatic logic direct_read(input host_rd_t r);
        return r.strobe & ~r.burst;
    endfunction

    function automatic logic irq_pending(input alarm_vec_t st, input alarm_vec_t mk);
        return |(st & mk);
    endfunction

endpackage

// File: rtl/rt_event_latch.sv
module rt_event_latch (
    input  logic clk,
    input  logic rst,
    input  logic cond_i,
    input  logic rd_clr_i,
    output logic bit_o
);

    logic cond_q;
    logic bit_q;
    logic rise;
    logic clr;

    assign rise = cond_i & ~cond_q;
    assign clr  = rd_clr_i & ~cond_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= 1'b0;
            bit_q  <= 1'b0;
        end else begin
            cond_q <= cond_i;
            bit_q  <= rise | (bit_q & ~clr);
        end
    end

    assign bit_o = bit_q;

    AST_RT_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
        (cond_i && !cond_q) |=> bit_q); // R5

    AST_RT_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_clr_i && !cond_i) |=> !bit_q); // R6

    AST_RT_HELD_STAYS: assert property (@(posedge clk) disable iff (rst)
        (bit_q && cond_i) |=> bit_q); // R7

    AST_RT_NO_RELATCH: assert property (@(posedge clk) disable iff (rst)
        (!bit_q && !cond_i) |=> !bit_q); // R11

endmodule

// File: rtl/sat_alarm_latch.sv
module sat_alarm_latch #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sat_set_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             bit_o
);

    logic bit_q;
    logic reload_clr;

    assign reload_clr = load_i & ~(&load_val_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q <= 1'b0;
        end else begin
            bit_q <= sat_set_i | (bit_q & ~reload_clr);
        end
    end

    assign bit_o = bit_q;

    AST_SAT_READ_IMMUNE: assert property (@(posedge clk) disable iff (rst)
        (bit_q && !(load_i && (load_val_i != {CNT_W{1'b1}}))) |=> bit_q); // R9

    AST_SAT_RELOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (load_i && (load_val_i != {CNT_W{1'b1}}) && !sat_set_i) |=> !bit_q); // R10

endmodule

// File: rtl/host_mask_reg.sv
module host_mask_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o
);

    logic [W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr_i) begin
            mask_q <= wdata_i;
        end
    end

    assign mask_o = mask_q;

endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
    import alarm_irq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [5:0]       evt_cond_i,
    input  logic [1:0]       sat_hit_i,
    input  logic [1:0]       cnt_load_i,
    input  logic [CNT_W-1:0] cnt_load_val_i,
    input  logic             rd_stb_i,
    input  logic             rd_burst_i,
    output logic [7:0]       rd_data_o,
    input  logic             mask_wr_i,
    input  logic [7:0]       mask_wdata_i,
    output logic [7:0]       mask_o,
    output logic             irq_n_o
);

    host_rd_t   rd_req;
    logic       rd_clr;
    logic [ALM_W-1:0] status;
    logic [ALM_W-1:0] mask;
    alarm_vec_t status_v;
    alarm_vec_t mask_v;

    assign rd_req.strobe = rd_stb_i;
    assign rd_req.burst  = rd_burst_i;
    assign rd_clr        = direct_read(rd_req);

    for (genvar i = 0; i < NUM_RT; i++) begin : g_rt
        rt_event_latch u_rt (
            .clk      (clk),
            .rst      (rst),
            .cond_i   (evt_cond_i[i]),
            .rd_clr_i (rd_clr),
            .bit_o    (status[i])
        );
    end

    for (genvar j = 0; j < NUM_SAT; j++) begin : g_sat
        sat_alarm_latch #(.CNT_W(CNT_W)) u_sat (
            .clk        (clk),
            .rst        (rst),
            .sat_set_i  (sat_hit_i[j]),
            .load_i     (cnt_load_i[j]),
            .load_val_i (cnt_load_val_i),
            .bit_o      (status[NUM_RT+j])
        );
    end

    host_mask_reg #(.W(ALM_W)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (mask_wr_i),
        .wdata_i (mask_wdata_i),
        .mask_o  (mask)
    );

    assign status_v  = alarm_vec_t'(status);
    assign mask_v    = alarm_vec_t'(mask);
    assign irq_n_o   = ~irq_pending(status_v, mask_v);
    assign rd_data_o = status;
    assign mask_o    = mask;

    AST_MASK_OFF_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (mask_wr_i && (mask_wdata_i == 8'h00)) |=> irq_n_o); // R4

    AST_BURST_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd_stb_i && rd_burst_i && (cnt_load_i == 2'b00))
        |=> ((rd_data_o & $past(rd_data_o)) == $past(rd_data_o))); // R8

endmodule

// File: tb/tb_alarm_irq_ctrl.sv
`timescale 1ns/1ps
module tb_alarm_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] evt_cond_i;
    logic [1:0] sat_hit_i;
    logic [1:0] cnt_load_i;
    logic [7:0] cnt_load_val_i;
    logic       rd_stb_i;
    logic       rd_burst_i;
    logic [7:0] rd_data_o;
    logic       mask_wr_i;
    logic [7:0] mask_wdata_i;
    logic [7:0] mask_o;
    logic       irq_n_o;

    always #2.5 clk = ~clk;

    alarm_irq_ctrl #(.CNT_W(8)) dut (
        .clk(clk), .rst(rst), .evt_cond_i(evt_cond_i), .sat_hit_i(sat_hit_i),
        .cnt_load_i(cnt_load_i), .cnt_load_val_i(cnt_load_val_i),
        .rd_stb_i(rd_stb_i), .rd_burst_i(rd_burst_i), .rd_data_o(rd_data_o),
        .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i), .mask_o(mask_o),
        .irq_n_o(irq_n_o)
    );

    typedef struct {
        int         due;
        logic [7:0] st;
        logic [7:0] mk;
        logic       irq_n;
        string      req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_checks = 0;
    int   n_fails = 0;
    bit   done = 1'b0;

    logic [7:0] m_st = '0;
    logic [7:0] m_mk = '0;
    logic [5:0] m_cq = '0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops every expectation due in this cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == cyc) begin
            exp_t it;
            it = q.pop_front();
            n_checks++;
            if (rd_data_o !== it.st || mask_o !== it.mk || irq_n_o !== it.irq_n) begin
                n_fails++;
                $display("FAIL %s: status=%h mask=%h irq_n=%b expected status=%h mask=%h irq_n=%b",
                         it.req, rd_data_o, mask_o, irq_n_o, it.st, it.mk, it.irq_n);
            end
        end
    end

    // Driver: applies one cycle of stimulus and pushes the expected result
    task automatic drive(input logic [5:0] c, input logic [1:0] s, input logic [1:0] ld,
                         input logic [7:0] lv, input logic rd, input logic bu,
                         input logic mw, input logic [7:0] md, input string req);
        logic [5:0] rise;
        logic [5:0] clr;
        exp_t e;
        @(negedge clk);
        evt_cond_i = c; sat_hit_i = s; cnt_load_i = ld; cnt_load_val_i = lv;
        rd_stb_i = rd; rd_burst_i = bu; mask_wr_i = mw; mask_wdata_i = md;
        rise = c & ~m_cq;
        clr  = (rd && !bu) ? ~c : 6'h00;
        m_st[5:0] = rise | (m_st[5:0] & ~clr);
        for (int j = 0; j < 2; j++)
            m_st[6+j] = s[j] | (m_st[6+j] & ~(ld[j] && lv != 8'hFF));
        m_cq = c;
        if (mw) m_mk = md;
        e.due = cyc + 1; e.st = m_st; e.mk = m_mk;
        e.irq_n = ~|(m_st & m_mk); e.req = req;
        q.push_back(e);
    endtask

    task automatic cond(input logic [5:0] c, input string req);
        drive(c, 2'b00, 2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, req);
    endtask

    task automatic rd(input logic [5:0] c, input logic bu, input string req);
        drive(c, 2'b00, 2'b00, 8'h00, 1'b1, bu, 1'b0, 8'h00, req);
    endtask

    task automatic wmask(input logic [7:0] md, input string req);
        drive(6'h00, 2'b00, 2'b00, 8'h00, 1'b0, 1'b0, 1'b1, md, req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        evt_cond_i = '0; sat_hit_i = '0; cnt_load_i = '0; cnt_load_val_i = '0;
        rd_stb_i = 0; rd_burst_i = 0; mask_wr_i = 0; mask_wdata_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R2: reset state
        n_checks++;
        if (rd_data_o !== 8'h00 || mask_o !== 8'h00 || irq_n_o !== 1'b1) begin
            n_fails++;
            $display("FAIL R2: status=%h mask=%h irq_n=%b expected 00 00 1", rd_data_o, mask_o, irq_n_o);
        end

        wmask(8'hFF, "R4 mask load");
        cond(6'h01, "R5 edge latch / R3 irq");
        cond(6'h00, "R5 short pulse held");
        rd(6'h00, 1'b1, "R8 burst read");
        rd(6'h00, 1'b0, "R6 direct read clear");
        cond(6'h08, "R5 framing set");
        rd(6'h08, 1'b0, "R7 held condition");
        rd(6'h0C, 1'b0, "R7 rise with read");
        cond(6'h04, "R11 after fall");
        rd(6'h04, 1'b0, "R6 partial clear");
        cond(6'h00, "R11 quiet");
        rd(6'h00, 1'b0, "R6 clear rest");
        cond(6'h00, "R11 no relatch");

        drive(6'h00, 2'b10, 2'b00, 8'h00, 0, 0, 0, 8'h00, "R9 bpv saturation");
        rd(6'h00, 1'b0, "R9 read immune");
        rd(6'h00, 1'b1, "R9 burst immune");
        drive(6'h00, 2'b00, 2'b10, 8'hFF, 0, 0, 0, 8'h00, "R10 reload ones keeps");
        drive(6'h00, 2'b00, 2'b01, 8'h00, 0, 0, 0, 8'h00, "R10 other counter");
        drive(6'h00, 2'b00, 2'b10, 8'h7F, 0, 0, 0, 8'h00, "R10 reload clears");

        drive(6'h00, 2'b01, 2'b00, 8'h00, 0, 0, 0, 8'h00, "R9 err saturation");
        wmask(8'hBF, "R4 mask off releases");
        wmask(8'hFF, "R4 mask on reasserts");
        wmask(8'h00, "R4 mask all off");
        drive(6'h00, 2'b00, 2'b01, 8'hFE, 0, 0, 0, 8'h00, "R10 err reload clears");

        for (int i = 0; i < 6; i++) begin
            cond(6'(1 << i), "R1 bit position");
            rd(6'h00, 1'b0, "R1 clear position");
        end

        drive(6'h3F, 2'b11, 2'b00, 8'h00, 0, 0, 0, 8'h00, "R1 all alarms");
        for (int i = 0; i < 8; i++)
            wmask(8'(1 << i), "R3 single mask bit");
        wmask(8'h00, "R3 no mask");
        rd(6'h00, 1'b0, "R6 R9 read mixed");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule